// File: doc/BRIEF.md
# USB Transmit Serializer

This block turns a byte stream from a serial interface engine into the two single-ended line levels of a USB port. The engine raises `tx_valid_i` with the first packet byte (the PID) on `tx_data_i`. It then offers each following byte and moves on whenever a rising clock edge sees `tx_valid_i` and `tx_ready_o` both high. The block places a SYNC field in front of the first byte. It shifts every byte out least significant bit first, inserts stuff bits, NRZI-encodes the result onto `line_dp_o`/`line_dm_o`, and closes the packet with an end-of-packet sequence. It never creates PID or CRC bytes: whatever the engine hands over is sent as is.

One bit lasts `BIT_CLKS` clocks. `BIT_CLKS` must be at least 2, so the one-byte holding register always refills before the shifter needs it. Lowering `tx_valid_i` marks the last byte. From then on `tx_ready_o` stays low until the end-of-packet idle level is on the line, even if the engine raises `tx_valid_i` early for the next packet. `line_state_o` reports the current line level, so the engine can confirm the bus is idle before it starts.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset, and again after a reset applied during a packet, the line is J (`line_dp_o`=1, `line_dm_o`=0), `line_state_o` is 2'b01 and `tx_ready_o` is low.
- R2: `tx_ready_o` rises only in the clock after an edge that saw `tx_valid_i` high, so it is never high in the first cycle of a new `tx_valid_i`.
- R3: A byte is taken on each rising edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is low in the following cycle, so each offered byte is taken exactly once.
- R4: Every packet starts from idle J with the SYNC bits 0,0,0,0,0,0,0,1 (byte value 8'h80 read least significant bit first), which appear on the line as K J K J K J K K.
- R5: The bytes taken are sent in order, each least significant bit first and unaltered. The first byte taken follows SYNC directly, and no byte is added or dropped between SYNC and end of packet.
- R6: NRZI: a 0 bit toggles the line between J and K and a 1 bit keeps the level, so the first bit time of every packet shows K.
- R7: After six consecutive 1 bits (the SYNC bits count), one 0 bit is inserted. This also applies when the run finishes the last byte, in which case the stuff bit comes before end of packet.
- R8: The packet ends at the first byte boundary with no byte waiting. The line is then SE0 for exactly two bit times and J after that. Each bit time is `BIT_CLKS` clocks.
- R9: Once `tx_valid_i` is low after a packet's first byte was taken, `tx_ready_o` stays low until J follows the SE0, even if `tx_valid_i` rises again. A packet waiting at that point is accepted at once, and its bytes do not merge into the previous packet.
- R10: `line_state_o` equals {`line_dm_o`, `line_dp_o`}: 2'b00 is SE0, 2'b01 is J, 2'b10 is K, and 2'b11 never occurs.
- R11: A packet of a single byte (PID only) is sent correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all handshakes sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid_i | input | 1 | Engine has a byte for the current packet; low ends the packet |
| tx_data_i | input | 8 | Byte offered to the block |
| tx_ready_o | output | 1 | Block takes `tx_data_i` on this edge if `tx_valid_i` is high |
| line_dp_o | output | 1 | Positive line level |
| line_dm_o | output | 1 | Negative line level |
| line_state_o | output | 2 | Line level: 00 SE0, 01 J, 10 K |

## Verification
The bench decodes the line on its own: it undoes NRZI and stuffing at bit rate and rebuilds the bytes. A design that shifted most significant bit first, skipped a stuff bit, or stuffed after five ones instead of six would produce wrong bytes or a wrong stuff count. Packets that end in six 1 bits target a design that goes straight to SE0 without the final stuff bit. The back-to-back case raises `tx_valid_i` again one clock after the previous packet closes. A design that re-armed `tx_ready_o` before the EOP finished would glue the second PID onto the first packet, and would show up as a handshake during the closing window and a wrong byte count. A reset applied in the middle of a packet checks that the line goes straight back to idle J.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_EOP
  } tx_state_e;

  // action for the line encoder in the current clock
  typedef enum logic [1:0] {
    LA_NONE,
    LA_BIT,
    LA_SE0,
    LA_J
  } line_act_e;

  localparam int          BYTE_W    = 8;
  localparam logic [7:0]  SYNC_BYTE = 8'h80;
  localparam logic [1:0]  LS_SE0    = 2'b00;
  localparam logic [1:0]  LS_J      = 2'b01;
  localparam logic [1:0]  LS_K      = 2'b10;

endpackage

// File: rtl/usbtx_tick_gen.sv
module usbtx_tick_gen #(
  parameter int BIT_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int            CW   = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/usbtx_stuffer.sv
module usbtx_stuffer #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  output logic stuff_o
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] ones_q;

  assign stuff_o = (ones_q == CW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst || clr_i)  ones_q <= '0;
    else if (step_i) begin
      if (stuff_o)     ones_q <= '0;
      else if (bit_i)  ones_q <= ones_q + 1'b1;
      else             ones_q <= '0;
    end
  end
endmodule

// File: rtl/usbtx_line_enc.sv
module usbtx_line_enc
  import usbtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_act_e act_i,
  input  logic      bit_i,
  output logic      dp_o,
  output logic      dm_o,
  output logic [1:0] state_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_o <= 1'b1;
      dm_o <= 1'b0;
    end else begin
      case (act_i)
        LA_BIT: if (!bit_i) begin
          dp_o <= ~dp_o;
          dm_o <= dp_o;
        end
        LA_SE0: begin
          dp_o <= 1'b0;
          dm_o <= 1'b0;
        end
        LA_J: begin
          dp_o <= 1'b1;
          dm_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign state_o = {dm_o, dp_o};
endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usbtx_pkg::*;
#(
  parameter int BIT_CLKS  = 4,
  parameter int STUFF_RUN = 6,
  parameter int SE0_BITS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_valid_i,
  input  logic [7:0] tx_data_i,
  output logic       tx_ready_o,
  output logic       line_dp_o,
  output logic       line_dm_o,
  output logic [1:0] line_state_o
);
  localparam int                BCW      = $clog2(BYTE_W);
  localparam logic [BCW-1:0]    LAST_BIT = BCW'(BYTE_W - 1);
  localparam logic [1:0]        SE0_END  = 2'(SE0_BITS);

  tx_state_e   state_q, state_d;
  logic [7:0]  sh_q, sh_d;
  logic [7:0]  hold_q, hold_d;
  logic        hold_full_q, hold_full_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic [1:0]  eop_q, eop_d;
  logic        closing_q, closing_d;
  logic        ready_q, ready_d;
  logic        accepting;
  logic        take;
  logic        tick;
  logic        stuff;
  line_act_e   act;
  logic        tx_bit;

  usbtx_tick_gen #(.BIT_CLKS(BIT_CLKS)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  usbtx_stuffer #(.RUN_LEN(STUFF_RUN)) u_stuff (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (state_q == ST_IDLE),
    .step_i  (act == LA_BIT),
    .bit_i   (tx_bit),
    .stuff_o (stuff)
  );

  usbtx_line_enc u_line (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act),
    .bit_i   (tx_bit),
    .dp_o    (line_dp_o),
    .dm_o    (line_dm_o),
    .state_o (line_state_o)
  );

  assign take = tx_valid_i && ready_q;

  always_comb begin
    state_d     = state_q;
    sh_d        = sh_q;
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    bcnt_d      = bcnt_q;
    eop_d       = eop_q;
    closing_d   = closing_q;
    act         = LA_NONE;
    tx_bit      = 1'b0;

    if (take) begin
      hold_d      = tx_data_i;
      hold_full_d = 1'b1;
    end

    case (state_q)
      ST_IDLE: begin
        if (tick && hold_full_q) begin
          state_d = ST_SYNC;
          sh_d    = SYNC_BYTE;
          bcnt_d  = '0;
        end
      end
      ST_SYNC, ST_DATA: begin
        if (tick) begin
          act = LA_BIT;
          if (stuff) begin
            tx_bit = 1'b0;
          end else begin
            tx_bit = sh_q[0];
            sh_d   = sh_q >> 1;
            bcnt_d = bcnt_q + 1'b1;
            if (bcnt_q == LAST_BIT) begin
              if (hold_full_q) begin
                sh_d        = hold_q;
                hold_full_d = 1'b0;
                state_d     = ST_DATA;
              end else begin
                state_d = ST_EOP;
                eop_d   = '0;
              end
            end
          end
        end
      end
      ST_EOP: begin
        if (tick) begin
          if (stuff) begin
            act    = LA_BIT;
            tx_bit = 1'b0;
          end else if (eop_q < SE0_END) begin
            act   = LA_SE0;
            eop_d = eop_q + 1'b1;
          end else begin
            act     = LA_J;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    // a packet stays closed from the drop of tx_valid until its EOP is out
    if (state_q == ST_EOP && state_d == ST_IDLE)
      closing_d = 1'b0;
    else if ((state_q != ST_IDLE || hold_full_q) && !tx_valid_i)
      closing_d = 1'b1;

    accepting = !closing_d && (state_d != ST_EOP);
    ready_d   = tx_valid_i && accepting && !hold_full_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      bcnt_q      <= '0;
      eop_q       <= '0;
      closing_q   <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      sh_q        <= sh_d;
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      bcnt_q      <= bcnt_d;
      eop_q       <= eop_d;
      closing_q   <= closing_d;
      ready_q     <= ready_d;
    end
  end

  assign tx_ready_o = ready_q;
endmodule

// File: rtl/usbtx_chk.sv
module usbtx_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       line_dp_o,
  input logic       line_dm_o,
  input logic [1:0] line_state_o
);
  logic pkt_q, closed_q, se0_seen_q;
  logic done_now;

  assign done_now = closed_q && se0_seen_q && (line_state_o == 2'b01);

  always_ff @(posedge clk) begin
    if (rst || done_now) begin
      pkt_q      <= 1'b0;
      closed_q   <= 1'b0;
      se0_seen_q <= 1'b0;
    end else begin
      if (tx_valid_i && tx_ready_o) pkt_q <= 1'b1;
      if (pkt_q && !tx_valid_i) closed_q <= 1'b1;
      if (closed_q && line_state_o == 2'b00) se0_seen_q <= 1'b1;
    end
  end

  // R2
  ready_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready_o) |-> $past(tx_valid_i));

  // R3
  single_take_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R9
  close_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (closed_q && !done_now) |-> !tx_ready_o);

  // R10
  no_se1_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_dp_o && line_dm_o) && (line_state_o != 2'b11));
endmodule

bind usb_tx_serializer usbtx_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_valid_i   (tx_valid_i),
  .tx_ready_o   (tx_ready_o),
  .line_dp_o    (line_dp_o),
  .line_dm_o    (line_dm_o),
  .line_state_o (line_state_o)
);

// File: tb/usb_tx_serializer_test.sv
module usb_tx_serializer_test;
  localparam int BIT_CLKS = 4;
  localparam int NPKT     = 6;
  localparam int NBYTE    = 14;
  // packets back to back in one table; lengths below
  localparam logic [7:0] VEC_DATA [NBYTE] = '{
    8'hC3,
    8'h2D, 8'h00, 8'h10,
    8'h4B, 8'hFF, 8'hFF, 8'h7F,
    8'hD2,
    8'h69, 8'hFC,
    8'hE1, 8'h3F, 8'h00
  };
  localparam int VEC_LEN [NPKT] = '{1, 3, 4, 1, 2, 3};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, dp, dm;
  logic [1:0] ls;

  int checks = 0;
  int fails  = 0;

  usb_tx_serializer #(.BIT_CLKS(BIT_CLKS)) uut (
    .clk          (clk),
    .rst          (rst),
    .tx_valid_i   (tx_valid),
    .tx_data_i    (tx_data),
    .tx_ready_o   (tx_ready),
    .line_dp_o    (dp),
    .line_dm_o    (dm),
    .line_state_o (ls)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- handshake monitors (negedge sampling) ----------------
  int  takes = 0, dbl_ready = 0, early_ready = 0, holdoff_viol = 0;
  int  close_req = 0, close_done = 0;
  logic prev_take = 1'b0, prev_valid = 1'b0, mon_se0 = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_take && tx_ready) dbl_ready++;
      if (tx_ready && !prev_valid) early_ready++;
      if (tx_valid && tx_ready) takes++;
      if (close_req > close_done) begin
        if (tx_ready && !(mon_se0 && ls == 2'b01)) holdoff_viol++;
        if (ls == 2'b00) mon_se0 = 1'b1;
        else if (mon_se0 && ls == 2'b01) begin
          mon_se0 = 1'b0;
          close_done++;
        end
      end
    end
    prev_take  = tx_valid && tx_ready;
    prev_valid = tx_valid;
  end

  // ---------------- line decoder ----------------
  logic [7:0] rx_buf [0:19];
  int rx_bits, rx_stuffs, rx_stuff_bad, rx_se0, rx_ls_mismatch;
  bit rx_end_j, rx_first_k, rx_last_stuff;

  task automatic decode_pkt();
    logic prev, lvl, bitv;
    logic [1:0] s;
    int ones, guard;
    bit done;
    for (int k = 0; k < 20; k++) rx_buf[k] = 8'h00;
    rx_bits = 0; rx_stuffs = 0; rx_stuff_bad = 0; rx_se0 = 0;
    rx_ls_mismatch = 0; rx_end_j = 0; rx_last_stuff = 0;
    @(negedge clk);
    guard = 0;
    while (ls == 2'b01 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    rx_first_k = (ls == 2'b10);
    prev = 1'b1; ones = 0; done = 0; guard = 0;
    while (!done && guard < 2000) begin
      guard++;
      s = ls;
      if (s != {dm, dp}) rx_ls_mismatch++;
      if (s == 2'b00) rx_se0++;
      else if (rx_se0 > 0) begin
        rx_end_j = (s == 2'b01);
        done = 1;
      end else begin
        lvl  = (s == 2'b01);
        bitv = (lvl == prev);
        prev = lvl;
        if (ones == 6) begin
          rx_stuffs++;
          if (bitv) rx_stuff_bad++;
          ones = 0;
          rx_last_stuff = 1;
        end else begin
          ones = bitv ? ones + 1 : 0;
          if (rx_bits < 160) rx_buf[rx_bits / 8][rx_bits % 8] = bitv;
          rx_bits++;
          rx_last_stuff = 0;
        end
      end
      if (!done) repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  // expected stuffing from the bit stream rule alone
  task automatic exp_stuff(input int st, input int len, output int n, output bit last);
    int ones;
    logic [7:0] b;
    ones = 0; n = 0; last = 0;
    for (int k = -1; k < len; k++) begin
      b = (k < 0) ? 8'h80 : VEC_DATA[st + k];
      for (int j = 0; j < 8; j++) begin
        if (ones == 6) begin
          n++;
          ones = 0;
        end
        ones = b[j] ? ones + 1 : 0;
      end
    end
    if (ones == 6) begin
      n++;
      last = 1;
    end
  endtask

  task automatic check_pkt(input int st, input int len);
    int n;
    bit last;
    chk(rx_first_k, "R6", "first line symbol is K", rx_first_k, 1);
    chk(rx_buf[0] == 8'h80, "R4", "sync byte", rx_buf[0], 8'h80);
    chk(rx_bits == (len + 1) * 8, "R5", "decoded bit count", rx_bits, (len + 1) * 8);
    for (int k = 0; k < len; k++)
      chk(rx_buf[k + 1] == VEC_DATA[st + k], "R5", "payload byte", rx_buf[k + 1], VEC_DATA[st + k]);
    exp_stuff(st, len, n, last);
    chk(rx_stuff_bad == 0, "R7", "stuff bit not zero", rx_stuff_bad, 0);
    chk(rx_stuffs == n, "R7", "stuff bit count", rx_stuffs, n);
    chk(rx_last_stuff == last, "R7", "stuff before EOP", rx_last_stuff, last);
    chk(rx_se0 == 2, "R8", "SE0 bit times", rx_se0, 2);
    chk(rx_end_j, "R8", "J after SE0", rx_end_j, 1);
    chk(rx_ls_mismatch == 0, "R10", "line_state vs pins", rx_ls_mismatch, 0);
  endtask

  task automatic send_pkt(input int st, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = VEC_DATA[st + i];
      if (i == 0) chk(tx_ready == 1'b0, "R2", "ready in first valid cycle", tx_ready, 0);
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b0;
    close_req++;
  endtask

  int start_of [NPKT];
  int total_bytes = 0;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    start_of[0] = 0;
    for (int p = 1; p < NPKT; p++) start_of[p] = start_of[p - 1] + VEC_LEN[p - 1];

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(tx_ready == 1'b0, "R1", "ready after reset", tx_ready, 0);
    chk(ls == 2'b01, "R1", "line_state after reset", ls, 1);
    chk(dp == 1'b1 && dm == 1'b0, "R1", "pins after reset", {dm, dp}, 1);
    repeat (5) @(negedge clk);

    // table walk: every packet, including one-byte packets (R11)
    for (int p = 0; p < NPKT; p++) begin
      fork
        send_pkt(start_of[p], VEC_LEN[p]);
        begin
          decode_pkt();
          check_pkt(start_of[p], VEC_LEN[p]);
        end
      join
      total_bytes += VEC_LEN[p];
      repeat (3) @(negedge clk);
    end
    chk(takes == total_bytes, "R3", "bytes taken", takes, total_bytes);

    // R9 / R11: next PID offered one clock after the previous packet closes
    fork
      begin
        send_pkt(start_of[3], VEC_LEN[3]);
        send_pkt(start_of[1], VEC_LEN[1]);
      end
      begin
        decode_pkt();
        check_pkt(start_of[3], VEC_LEN[3]);
        decode_pkt();
        check_pkt(start_of[1], VEC_LEN[1]);
      end
    join
    total_bytes += VEC_LEN[3] + VEC_LEN[1];
    repeat (4) @(negedge clk);
    chk(holdoff_viol == 0, "R9", "ready during close window", holdoff_viol, 0);
    chk(takes == total_bytes, "R3", "bytes taken back to back", takes, total_bytes);
    chk(dbl_ready == 0, "R3", "ready high after take", dbl_ready, 0);
    chk(early_ready == 0, "R2", "ready without prior valid", early_ready, 0);

    // R1 reset in mid packet
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = 8'hFF;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    tx_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(ls == 2'b01, "R1", "line_state after mid reset", ls, 1);
    chk(tx_ready == 1'b0, "R1", "ready after mid reset", tx_ready, 0);
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk(ls == 2'b01, "R1", "line stays idle after mid reset", ls, 1);

    // recovery packet after reset
    fork
      send_pkt(start_of[4], VEC_LEN[4]);
      begin
        decode_pkt();
        check_pkt(start_of[4], VEC_LEN[4]);
      end
    join

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule